// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache

This block sits between a processor's load/store port and a slower word-wide main memory. It holds sixteen single-word lines. Each line has a valid bit, a dirty bit, a stored tag and one data word. A processor access is captured into internal registers, and the stored tag of the selected line is compared against the request. On a hit the block answers from its own storage. On a miss it brings the line in from memory. If the line being replaced holds modified data, that data is written out to memory first.

Writes are absorbed in the cache and reach memory only when the modified line is later replaced. A write that misses first fetches the word, installs it, and then overwrites it in a separate merge step, which leaves the line valid and dirty. The processor sees `cpu_busy` while an access is in flight. Completion is a one-cycle `cpu_done` pulse, and on reads `cpu_rdata` is valid with that pulse. The memory side uses a request/ready handshake of arbitrary latency.

Top module: `wb_dm_cache`

## Requirements
- R1: After reset `cpu_busy`, `cpu_done` and `mem_req` are 0 and every line is invalid, so the first access to any address is a miss.
- R2: A word address is split into tag = addr[31:6], line index = addr[5:2], and addr[1:0] ignored; two addresses that differ only in bits [1:0] hit the same stored word.
- R3: A read hit pulses `cpu_done` two clock edges after the request is sampled, returns the stored word on `cpu_rdata`, and causes no memory request.
- R4: A write hit replaces the stored word, marks the line dirty, completes two edges after acceptance and causes no memory traffic; a later read returns the new word.
- R5: A miss whose victim is invalid or clean issues exactly one memory read at {req tag, index, 2'b00} and no memory write; it installs the line valid and clean; a read returns the fetched word 5+L edges after acceptance (L = memory wait cycles).
- R6: A miss whose victim is valid and dirty first writes the victim word to {victim tag, index, 2'b00}, and only after that write is acknowledged issues the read; a read completes 8+2L edges after acceptance and memory holds the victim word afterwards.
- R7: A write miss fetches and installs the word, then overwrites it with the write data in an extra cycle and marks it dirty; it completes 6+L edges (clean victim) or 9+2L edges (dirty victim) after acceptance.
- R8: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from the rise of `mem_req` until the cycle in which `mem_ready` is seen, and `mem_req` is low in the following cycle; a write-back is followed, one idle cycle later, by a read request.
- R9: `cpu_busy` is high from the cycle after acceptance until `cpu_done`; `cpu_done` lasts exactly one cycle and `cpu_busy` is low during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write data |
| cpu_busy | output | 1 | Access in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_done` on reads |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory acknowledges the current request (one cycle) |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |

## Verification
The handshake properties assume that `mem_ready` is raised only while `mem_req` is high, for a single cycle, and that `mem_rdata` is valid in that cycle. The bench's memory model only counts wait cycles while a request is pending, answers exactly once per request and drops ready on the next edge. The completion properties assume that requests arrive only while the cache is idle. The stimulus therefore issues each access only after the previous `cpu_done`, and it holds `cpu_req` for just the one cycle in which it is sampled.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_LOOKUP    = 3'd1,
    ST_WRITEBACK = 3'd2,
    ST_ALLOCATE  = 3'd3,
    ST_UPDATE    = 3'd4
  } wbc_state_e;
endpackage

// File: rtl/wbc_meta_store.sv
module wbc_meta_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 26,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  input  logic [IDX_W-1:0] q_idx,
  output logic             q_valid,
  output logic             q_dirty,
  input  logic             line_wr,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             dirty_set
);
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_r;
  logic [LINES-1:0] dirty_r;

  // tag array: synchronous read, no reset, so it maps onto RAM
  always_ff @(posedge clk) begin
    if (line_wr) tag_mem[q_idx] <= line_tag;
    rd_tag <= tag_mem[rd_idx];
  end

  // status bits live in flops so reset can clear them in one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r <= '0;
      dirty_r <= '0;
    end else begin
      if (line_wr) begin
        valid_r[q_idx] <= 1'b1;
        dirty_r[q_idx] <= 1'b0;
      end
      if (dirty_set) dirty_r[q_idx] <= 1'b1;
    end
  end

  assign q_valid = valid_r[q_idx];
  assign q_dirty = dirty_r[q_idx];
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFS_W = $clog2(DATA_W / 8),
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W,
  localparam int WA_W  = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [WA_W-1:0]   cpu_waddr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  line_idx,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [DATA_W-1:0] st_data,
  input  logic              st_valid,
  input  logic              st_dirty,
  output logic              data_we,
  output logic [DATA_W-1:0] data_wd,
  output logic              line_wr,
  output logic [TAG_W-1:0]  line_tag,
  output logic              dirty_set
);
  wbc_state_e        state;
  logic [WA_W-1:0]   req_wa;
  logic              req_we;
  logic [DATA_W-1:0] req_wd;
  logic              hit;
  logic              mem_ack;

  assign line_idx = req_wa[IDX_W-1:0];
  assign line_tag = req_wa[WA_W-1:IDX_W];
  // while idle the RAMs look at the incoming index so data is ready in LOOKUP
  assign rd_idx   = (state == ST_IDLE) ? cpu_waddr[IDX_W-1:0] : line_idx;
  assign hit      = st_valid && (st_tag == line_tag);
  assign mem_ack  = mem_req && mem_ready;

  always_comb begin
    data_we   = 1'b0;
    dirty_set = 1'b0;
    line_wr   = 1'b0;
    data_wd   = req_wd;
    case (state)
      ST_LOOKUP: begin
        data_we   = hit && req_we;
        dirty_set = hit && req_we;
      end
      ST_ALLOCATE: begin
        data_we = mem_ack;
        line_wr = mem_ack;
        data_wd = mem_rdata;
      end
      ST_UPDATE: begin
        data_we   = 1'b1;
        dirty_set = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cpu_busy  <= 1'b0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      req_wa    <= '0;
      req_we    <= 1'b0;
      req_wd    <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (state)
        ST_IDLE: if (cpu_req) begin
          req_wa   <= cpu_waddr;
          req_we   <= cpu_we;
          req_wd   <= cpu_wdata;
          cpu_busy <= 1'b1;
          state    <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (hit) begin
            if (!req_we) cpu_rdata <= st_data;
            cpu_done <= 1'b1;
            cpu_busy <= 1'b0;
            state    <= ST_IDLE;
          end else if (st_valid && st_dirty) begin
            state <= ST_WRITEBACK;
          end else begin
            state <= ST_ALLOCATE;
          end
        end
        ST_WRITEBACK: begin
          if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {st_tag, line_idx, {OFS_W{1'b0}}};
            mem_wdata <= st_data;
          end else if (mem_ready) begin
            mem_req <= 1'b0;
            state   <= ST_ALLOCATE;
          end
        end
        ST_ALLOCATE: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {req_wa, {OFS_W{1'b0}}};
          end else if (mem_ready) begin
            mem_req <= 1'b0;
            if (req_we) begin
              state <= ST_UPDATE;
            end else begin
              cpu_rdata <= mem_rdata;
              cpu_done  <= 1'b1;
              cpu_busy  <= 1'b0;
              state     <= ST_IDLE;
            end
          end
        end
        ST_UPDATE: begin
          cpu_done <= 1'b1;
          cpu_busy <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R8
  mem_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready) |=> !mem_req);
  // R6 R8
  wb_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_req) && $past(mem_we)) |=> (mem_req && !mem_we));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> ($past(cpu_busy) && !cpu_busy));
  // R3 R4
  done_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !mem_req);
endmodule

// File: rtl/wb_dm_cache.sv
module wb_dm_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFS_W = $clog2(DATA_W / 8),
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W,
  localparam int WA_W  = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [IDX_W-1:0]  rd_idx, line_idx;
  logic [TAG_W-1:0]  st_tag, line_tag;
  logic [DATA_W-1:0] st_data, data_wd;
  logic              st_valid, st_dirty, data_we, line_wr, dirty_set;

  wbc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_waddr(cpu_addr[ADDR_W-1:OFS_W]),
    .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .rd_idx(rd_idx), .line_idx(line_idx),
    .st_tag(st_tag), .st_data(st_data), .st_valid(st_valid), .st_dirty(st_dirty),
    .data_we(data_we), .data_wd(data_wd), .line_wr(line_wr), .line_tag(line_tag),
    .dirty_set(dirty_set)
  );

  wbc_meta_store #(.LINES(LINES), .TAG_W(TAG_W)) u_meta (
    .clk(clk), .rst(rst),
    .rd_idx(rd_idx), .rd_tag(st_tag),
    .q_idx(line_idx), .q_valid(st_valid), .q_dirty(st_dirty),
    .line_wr(line_wr), .line_tag(line_tag), .dirty_set(dirty_set)
  );

  wbc_data_store #(.LINES(LINES), .DATA_W(DATA_W)) u_data (
    .clk(clk),
    .rd_idx(rd_idx), .rd_data(st_data),
    .wr_en(data_we), .wr_idx(line_idx), .wr_data(data_wd)
  );
endmodule

// File: tb/test_wb_dm_cache.sv
module test_wb_dm_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_busy, cpu_done;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  int mem_lat = 2;
  int wait_cnt = 0;
  int n_rd = 0, n_wr = 0;
  logic [31:0] last_wr_addr, last_wr_data;
  bit finished = 0;

  always #4 clk = ~clk;

  wb_dm_cache i_wb_dm_cache (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem_words [logic [29:0]];
  logic [31:0] ref_mem   [logic [29:0]];
  bit          rv [16];
  bit          rdty [16];
  logic [25:0] rtag [16];
  logic [31:0] rdat [16];

  function automatic logic [31:0] seed_word(logic [29:0] wa);
    return ({2'b00, wa} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] mem_peek(logic [29:0] wa);
    if (mem_words.exists(wa)) return mem_words[wa];
    return seed_word(wa);
  endfunction

  function automatic logic [31:0] ref_peek(logic [29:0] wa);
    if (ref_mem.exists(wa)) return ref_mem[wa];
    return seed_word(wa);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model with programmable wait cycles
  always @(posedge clk) begin
    if (rst) begin
      mem_ready <= 1'b0;
      wait_cnt  <= 0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= mem_lat) begin
        mem_ready <= 1'b1;
        wait_cnt  <= 0;
        if (mem_we) begin
          mem_words[mem_addr[31:2]] = mem_wdata;
          last_wr_addr <= mem_addr;
          last_wr_data <= mem_wdata;
          n_wr <= n_wr + 1;
        end else begin
          mem_rdata <= mem_peek(mem_addr[31:2]);
          n_rd <= n_rd + 1;
        end
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  // per-cycle handshake and pulse monitor
  logic        p_req, p_rdy, p_we, p_done;
  logic [31:0] p_addr, p_wd;
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (p_req && !p_rdy)
        check(mem_req && mem_we == p_we && mem_addr == p_addr && mem_wdata == p_wd,
              "R8", "request held until ready", mem_addr, p_addr);
      if (p_req && p_rdy)
        check(!mem_req, "R8", "request dropped after ready", {31'b0, mem_req}, 32'd0);
      if (p_done)
        check(!cpu_done, "R9", "done lasts one cycle", {31'b0, cpu_done}, 32'd0);
    end
    p_req = mem_req; p_rdy = mem_ready; p_we = mem_we;
    p_addr = mem_addr; p_wd = mem_wdata; p_done = cpu_done;
  end

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        input string req);
    logic [3:0]  idx = addr[5:2];
    logic [25:0] tg  = addr[31:6];
    bit          hit = rv[idx] && rtag[idx] == tg;
    bit          ev  = !hit && rv[idx] && rdty[idx];
    logic [31:0] ev_addr = {rtag[idx], idx, 2'b00};
    logic [31:0] ev_data = rdat[idx];
    logic [31:0] exp_rd;
    int exp_n, n, rd0, wr0;
    if (hit)     exp_n = 2;
    else if (ev) exp_n = (we ? 9 : 8) + 2 * mem_lat;
    else         exp_n = (we ? 6 : 5) + mem_lat;
    if (ev) ref_mem[ev_addr[31:2]] = ev_data;
    if (!hit) begin
      rdat[idx] = ref_peek(addr[31:2]);
      rtag[idx] = tg; rv[idx] = 1; rdty[idx] = 0;
    end
    exp_rd = rdat[idx];
    if (we) begin rdat[idx] = wd; rdty[idx] = 1; end
    rd0 = n_rd; wr0 = n_wr;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 0;
    n = 1;
    while (!cpu_done && n < 400) begin
      if (!cpu_busy) check(0, "R9", {req, " busy during access"}, 32'd0, 32'd1);
      @(negedge clk);
      n++;
    end
    check(n == exp_n, req, "completion edge count", n, exp_n);
    check(!cpu_busy, "R9", "busy low with done", {31'b0, cpu_busy}, 32'd0);
    if (!we) check(cpu_rdata == exp_rd, req, "read data", cpu_rdata, exp_rd);
    check(n_rd - rd0 == (hit ? 0 : 1), req, "memory reads", n_rd - rd0, hit ? 0 : 1);
    check(n_wr - wr0 == (ev ? 1 : 0), req, "memory writes", n_wr - wr0, ev ? 1 : 0);
    if (ev) begin
      check(last_wr_addr == ev_addr, "R6", "write-back address", last_wr_addr, ev_addr);
      check(mem_peek(ev_addr[31:2]) == ev_data, "R6", "write-back contents",
            mem_peek(ev_addr[31:2]), ev_data);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state at the ports
    check(!cpu_busy && !cpu_done && !mem_req, "R1", "outputs idle after reset",
          {29'b0, cpu_busy, cpu_done, mem_req}, 32'd0);
    access(0, 32'h0000_1004, '0, "R1_R5");            // cold read miss
    access(0, 32'h0000_1004, '0, "R3");               // read hit
    access(0, 32'h0000_1006, '0, "R2");               // offset bits ignored
    access(1, 32'h0000_1005, 32'hCAFE_0001, "R4");    // write hit
    access(0, 32'h0000_1004, '0, "R4");               // read back modified
    access(0, 32'h0000_1044, '0, "R6");               // same index, dirty victim
    access(0, 32'h0000_1004, '0, "R5");               // clean victim, no write-back
    access(1, 32'h0000_2008, 32'hBEEF_0002, "R7");    // write miss, invalid victim
    access(0, 32'h0000_2008, '0, "R7");               // allocated data visible
    access(1, 32'h0000_2048, 32'h1234_5678, "R7");    // write miss, dirty victim
    access(0, 32'h0000_2008, '0, "R6");               // evicts the write-allocated line
    mem_lat = 0;
    for (int i = 0; i < 16; i++) access(1, 32'h0000_4000 + i * 4, 32'hA000_0000 + i, "R7");
    mem_lat = 5;
    for (int i = 0; i < 16; i++) access(0, 32'h0000_8000 + i * 4, '0, "R6");
    for (int i = 0; i < 16; i++) access(0, 32'h0000_4000 + i * 4, '0, "R5");
    mem_lat = 1;
    for (int i = 0; i < 8; i++) access(i % 2, 32'h0001_0000 + i * 68, 32'h0F0F_0000 ^ i, "R2");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule